// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block watches eight level-sensitive interrupt lines and turns each new assertion into a 32-bit message write addressed to a CPU. Every line has two words in a redirection table. The control word carries a mask bit, trigger and polarity flags, and a 6-bit vector. The destination word holds the CPU address in a byte-swapped (swizzled) form. Software cannot address the table directly. It writes an entry number into a select register and then reads or writes that entry through a data window. A separate end-of-interrupt (EOI) register releases pending lines by vector.

A pending-line register holds one bit per line position. The position is taken from the low bits of the control word. A message is produced only when a pending bit goes from clear to set. The message addresses the unswizzled destination and carries the vector as data. Messages leave on a valid/ready handshake. Every position has a one-entry holding slot, so messages that become due while the output is stalled are kept and sent later in ascending position order.

The register bus is 64 bits wide and accepts 32-bit or 64-bit accesses. Register offsets are: select at 0x800, window at 0x810, EOI at 0x840.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset the pending register is zero, no message is valid and the select register reads 0. Control entry 0x10+2i reads 0x1A000+(i+2): bit 16 set (masked), bit 15 set (level), bit 13 set (active low), vector i+2. Destination entry 0x11+2i reads the swizzled CPU address, which is 0xA0FF0000 for the default 0xFFFA0000.
- R2: A write to select (0x800) picks a table entry. A 64-bit write to the window (0x810) replaces that entry, and a 64-bit window read returns it.
- R3: A 32-bit window access works on one half of the entry. Byte address bit 2 clear selects bits 31:0 and bit 2 set selects bits 63:32. Write data is taken from bits 31:0, and read data is returned in bits 31:0 with bits 63:32 zero.
- R4: With select equal to 1, a window read returns 0x00200001: the entry count 32 in bits 31:16 and 1 in the low bits.
- R5: With a select value above 0x1F, a window read returns all ones and a window write changes no entry.
- R6: Line i sets pending bit ctrl[2:0] on the clock edge after it is high, provided its control bit 16 is clear and its stored destination is nonzero.
- R7: A pending bit going from 0 to 1 produces exactly one message. The message data is ctrl[5:0] and its address is {4'hF, dest[23:16], dest[31:24], 12'h000}. It becomes valid two edges after the line rises. While the line stays high, no further message is produced.
- R8: A line that is low, or whose mask bit is set, clears its pending bit on the next edge.
- R9: An EOI write clears the pending bit of every line whose control bits 5:0 equal the written bits 5:0. A line that is still high sets the bit again on the following edge and sends a new message. An EOI vector that matches no line has no effect.
- R10: While msg_ready_i is low, a valid message keeps its address and data. Messages that become due meanwhile are all delivered later, lowest pending position first.
- R11: A line whose stored destination is zero never sets its pending bit and never produces a message.
- R12: If an EOI clear and a line setting the same pending bit fall in the same cycle, the clear wins for that edge. The bit sets on the next edge and exactly one message is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IN | Level interrupt lines |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 for a write, 0 for a read |
| reg_wide_i | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| reg_addr_i | input | ADDR_W-2 | Byte address bits ADDR_W-1:2 |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, combinational from the address |
| pend_o | output | N_IN | Pending-line register |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_ready_i | input | 1 | Outgoing message accepted |
| msg_addr_o | output | 32 | Message target address |
| msg_data_o | output | 32 | Message data (vector) |

## Verification
Two functions can act on the same pending bit in one cycle: an EOI clear and a line's level evaluation setting it. The bench provokes this by raising a line on the same edge that it issues the EOI for that line's vector. It then expects the bit to stay clear at that edge, to be set on the next edge, and exactly one message to follow. The second overlap is a new message becoming due while the output stalls. The bench holds ready low while all eight lines rise together, checks that the held message does not change, and then checks the order of the eight drained messages.

// File: rtl/irq_redirect_pkg.sv
package irq_redirect_pkg;
  localparam int unsigned VEC_W   = 6;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned SEL_BYTE_OFS = 32'h800;
  localparam int unsigned WIN_BYTE_OFS = 32'h810;
  localparam int unsigned EOI_BYTE_OFS = 32'h840;
  localparam int unsigned MASK_BIT  = 16;
  localparam int unsigned LEVEL_BIT = 15;
  localparam int unsigned LOWPOL_BIT = 13;

  function automatic logic [31:0] hpa_pack(input logic [31:0] a);
    return {a[19:12], a[27:20], 16'h0000};
  endfunction

  function automatic logic [31:0] hpa_unpack(input logic [31:0] s);
    return {4'hF, s[23:16], s[31:24], 12'h000};
  endfunction
endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redirect_pkg::*;
#(
  parameter int unsigned N_IN     = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned SEL_W    = 8,
  parameter logic [31:0] CPU_ADDR = 32'hFFFA_0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic                 wide_i,
  input  logic [ADDR_W-1:2]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [N_IN-1:0]      mask_o,
  output logic [VEC_W-1:0]     vec_o  [N_IN],
  output logic [31:0]          dest_o [N_IN],
  output logic                 eoi_v_o,
  output logic [VEC_W-1:0]     eoi_vec_o
);
  localparam int unsigned TBL_N = 16 + 2 * N_IN;
  localparam int unsigned IDX_W = $clog2(TBL_N);
  localparam int unsigned OFS_W = ADDR_W - 3;
  localparam logic [OFS_W-1:0] OFS_SEL = OFS_W'(SEL_BYTE_OFS >> 3);
  localparam logic [OFS_W-1:0] OFS_WIN = OFS_W'(WIN_BYTE_OFS >> 3);
  localparam logic [OFS_W-1:0] OFS_EOI = OFS_W'(EOI_BYTE_OFS >> 3);
  localparam logic [31:0] VERSION = {16'(TBL_N), 16'h0001};

  function automatic logic [WORD_W-1:0] rst_word(input int unsigned e);
    logic [WORD_W-1:0] w;
    w = '0;
    if (e >= 16 && ((e - 16) % 2) == 0)
      w = 64'((32'h1 << MASK_BIT) | (32'h1 << LEVEL_BIT) | (32'h1 << LOWPOL_BIT)
              | 32'((e - 16) / 2 + 2));
    else if (e >= 16)
      w = {32'h0, hpa_pack(CPU_ADDR)};
    return w;
  endfunction

  logic [WORD_W-1:0] tbl_q [TBL_N];
  logic [SEL_W-1:0]  sel_q;
  logic [OFS_W-1:0]  ofs;
  logic              sel_ok, hi_half;
  logic              wr_sel, wr_win;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] rd64;

  assign ofs     = addr_i[ADDR_W-1:3];
  assign hi_half = addr_i[2];
  assign sel_ok  = (sel_q < SEL_W'(TBL_N));
  assign idx     = sel_q[IDX_W-1:0];
  assign wr_sel  = req_i && we_i && (ofs == OFS_SEL);
  assign wr_win  = req_i && we_i && (ofs == OFS_WIN);
  assign eoi_v_o   = req_i && we_i && (ofs == OFS_EOI);
  assign eoi_vec_o = wdata_i[VEC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (wr_sel) sel_q <= wdata_i[SEL_W-1:0];
  end

  generate
    for (genvar e = 0; e < TBL_N; e++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tbl_q[e] <= rst_word(e);
        else if (wr_win && sel_ok && idx == IDX_W'(e)) begin
          if (wide_i)       tbl_q[e] <= wdata_i;
          else if (hi_half) tbl_q[e][63:32] <= wdata_i[31:0];
          else              tbl_q[e][31:0]  <= wdata_i[31:0];
        end
      end
      // R5
      win_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_win && !sel_ok) |=> $stable(tbl_q[e]));
    end
    for (genvar i = 0; i < N_IN; i++) begin : g_out
      assign mask_o[i] = tbl_q[16 + 2 * i][MASK_BIT];
      assign vec_o[i]  = tbl_q[16 + 2 * i][VEC_W-1:0];
      assign dest_o[i] = tbl_q[17 + 2 * i][31:0];
    end
  endgenerate

  always_comb begin
    rd64 = '0;
    if (ofs == OFS_SEL) rd64 = WORD_W'(sel_q);
    else if (ofs == OFS_WIN) begin
      if (!sel_ok)                 rd64 = '1;
      else if (sel_q == SEL_W'(1)) rd64 = WORD_W'(VERSION);
      else                         rd64 = tbl_q[idx];
    end
    if (wide_i)       rdata_o = rd64;
    else if (hi_half) rdata_o = {32'h0, rd64[63:32]};
    else              rdata_o = {32'h0, rd64[31:0]};
  end
endmodule

// File: rtl/irq_redir_pend.sv
module irq_redir_pend
  import irq_redirect_pkg::*;
#(
  parameter int unsigned N_IN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  irq_i,
  input  logic [N_IN-1:0]  mask_i,
  input  logic [VEC_W-1:0] vec_i  [N_IN],
  input  logic [31:0]      dest_i [N_IN],
  input  logic             eoi_v_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  output logic [N_IN-1:0]  pend_o,
  output logic [N_IN-1:0]  rise_o,
  output logic [VEC_W-1:0] rise_vec_o  [N_IN],
  output logic [31:0]      rise_addr_o [N_IN]
);
  localparam int unsigned PB_W = $clog2(N_IN);

  logic [N_IN-1:0] pend_q, act, hit, set, eclr, pend_n;
  logic [PB_W-1:0] pos [N_IN];

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      pos[i] = vec_i[i][PB_W-1:0];
      act[i] = irq_i[i] && !mask_i[i] && (dest_i[i] != '0);
    end
    for (int b = 0; b < N_IN; b++) begin
      hit[b] = 1'b0;
      set[b] = 1'b0;
      eclr[b] = 1'b0;
      rise_vec_o[b]  = '0;
      rise_addr_o[b] = '0;
      for (int i = N_IN - 1; i >= 0; i--) begin
        if (pos[i] == PB_W'(b)) begin
          hit[b] = 1'b1;
          if (eoi_v_i && vec_i[i] == eoi_vec_i) eclr[b] = 1'b1;
          if (act[i]) begin
            set[b] = 1'b1;
            rise_vec_o[b]  = vec_i[i];
            rise_addr_o[b] = hpa_unpack(dest_i[i]);
          end
        end
      end
      pend_n[b] = (hit[b] ? set[b] : pend_q[b]) && !eclr[b];
      rise_o[b] = set[b] && !pend_q[b] && !eclr[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_n;
  end

  assign pend_o = pend_q;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_chk
      // R9
      eoi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_v_i && vec_i[i] == eoi_vec_i) |=> !pend_q[$past(pos[i])]);
    end
  endgenerate
endmodule

// File: rtl/irq_redir_msgq.sv
module irq_redir_msgq
  import irq_redirect_pkg::*;
#(
  parameter int unsigned N_IN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  rise_i,
  input  logic [VEC_W-1:0] rise_vec_i  [N_IN],
  input  logic [31:0]      rise_addr_i [N_IN],
  output logic [N_IN-1:0]  slot_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [31:0]      addr_o,
  output logic [31:0]      data_o
);
  logic [N_IN-1:0]  flag_q, pick;
  logic [VEC_W-1:0] vec_q  [N_IN];
  logic [31:0]      addr_q [N_IN];
  logic             out_v_q, take;
  logic [VEC_W-1:0] out_vec_q, pick_vec;
  logic [31:0]      out_addr_q, pick_addr;

  always_comb begin
    pick = '0;
    pick_vec = '0;
    pick_addr = '0;
    for (int b = N_IN - 1; b >= 0; b--) begin
      if (flag_q[b]) begin
        pick = '0;
        pick[b] = 1'b1;
        pick_vec = vec_q[b];
        pick_addr = addr_q[b];
      end
    end
  end

  assign take = (!out_v_q || ready_i) && (flag_q != '0);

  generate
    for (genvar b = 0; b < N_IN; b++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q[b] <= 1'b0;
          vec_q[b]  <= '0;
          addr_q[b] <= '0;
        end else begin
          flag_q[b] <= (flag_q[b] && !(take && pick[b])) || rise_i[b];
          if (rise_i[b]) begin
            vec_q[b]  <= rise_vec_i[b];
            addr_q[b] <= rise_addr_i[b];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q    <= 1'b0;
      out_vec_q  <= '0;
      out_addr_q <= '0;
    end else if (take) begin
      out_v_q    <= 1'b1;
      out_vec_q  <= pick_vec;
      out_addr_q <= pick_addr;
    end else if (ready_i) begin
      out_v_q <= 1'b0;
    end
  end

  assign slot_o  = flag_q;
  assign valid_o = out_v_q;
  assign addr_o  = out_addr_q;
  assign data_o  = 32'(out_vec_q);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));
  // R10
  one_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick));
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irq_redirect_pkg::*;
#(
  parameter int unsigned N_IN     = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned SEL_W    = 8,
  parameter logic [31:0] CPU_ADDR = 32'hFFFA_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   irq_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic              reg_wide_i,
  input  logic [ADDR_W-1:2] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic [N_IN-1:0]   pend_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [31:0]       msg_addr_o,
  output logic [31:0]       msg_data_o
);
  logic [N_IN-1:0]  mask, rise, slot;
  logic [VEC_W-1:0] vec [N_IN];
  logic [31:0]      dest [N_IN];
  logic             eoi_v;
  logic [VEC_W-1:0] eoi_vec;
  logic [VEC_W-1:0] rise_vec [N_IN];
  logic [31:0]      rise_addr [N_IN];

  irq_redir_regs #(.N_IN(N_IN), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .CPU_ADDR(CPU_ADDR)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .wide_i(reg_wide_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .mask_o(mask), .vec_o(vec), .dest_o(dest),
    .eoi_v_o(eoi_v), .eoi_vec_o(eoi_vec)
  );

  irq_redir_pend #(.N_IN(N_IN)) u_pend (
    .clk_i, .rst_ni, .irq_i,
    .mask_i(mask), .vec_i(vec), .dest_i(dest),
    .eoi_v_i(eoi_v), .eoi_vec_i(eoi_vec),
    .pend_o, .rise_o(rise), .rise_vec_o(rise_vec), .rise_addr_o(rise_addr)
  );

  irq_redir_msgq #(.N_IN(N_IN)) u_msgq (
    .clk_i, .rst_ni,
    .rise_i(rise), .rise_vec_i(rise_vec), .rise_addr_i(rise_addr),
    .slot_o(slot),
    .valid_o(msg_valid_o), .ready_i(msg_ready_i),
    .addr_o(msg_addr_o), .data_o(msg_data_o)
  );

  generate
    for (genvar b = 0; b < N_IN; b++) begin : g_chk
      // R7
      rise_queued_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_o[b]) |-> slot[b]);
    end
  endgenerate

  // R7
  msg_addr_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_addr_o[31:28] == 4'hF && msg_data_o[31:VEC_W] == '0));
endmodule

// File: tb/irq_redirect_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [11:2] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [N-1:0] pend;
  logic        mvalid, mready = 1'b1;
  logic [31:0] maddr, mdata;

  int unsigned total = 0, bad = 0, n_msg = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];

  always #10 clk = ~clk;

  irq_redirect_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_req_i(req), .reg_we_i(we), .reg_wide_i(wide),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pend_o(pend), .msg_valid_o(mvalid), .msg_ready_i(mready),
    .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  always @(posedge clk) begin
    if (rst_n && mvalid && mready) begin
      if (n_msg < 64) begin
        log_addr[n_msg] = maddr;
        log_data[n_msg] = mdata;
      end
      n_msg = n_msg + 1;
    end
  end

  function automatic logic [31:0] unpack_hpa(input logic [31:0] s);
    return 32'hF000_0000 | ((s << 4) & 32'h0FF0_0000) | ((s >> 12) & 32'h000F_F000);
  endfunction
  function automatic logic [63:0] pat(input int e);
    return 64'h0123_4567_89AB_CDEF ^ (64'(e) * 64'h1111_1111_1111_1111);
  endfunction
  function automatic int posn(input int i);
    return (i + 3) % 8;
  endfunction
  function automatic logic [5:0] vecn(input int i);
    return 6'(i * 8 + posn(i));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic w);
    @(negedge clk);
    req = 1'b1; we = 1'b1; wide = w; addr = a[11:2]; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic w, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; wide = w; addr = a[11:2];
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic win_wr(input int e, input logic [63:0] d);
    wr(12'h800, 64'(e), 1'b1);
    wr(12'h810, d, 1'b1);
  endtask

  task automatic win_rd(input int e, output logic [63:0] d);
    wr(12'h800, 64'(e), 1'b1);
    rd(12'h810, 1'b1, d);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int base;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    chk("R1 pend", 64'(pend), 64'h0);
    chk("R1 valid", 64'(mvalid), 64'h0);
    rd(12'h800, 1'b1, d);
    chk("R1 select", d, 64'h0);
    for (int i = 0; i < N; i++) begin
      win_rd(16 + 2 * i, d);
      chk("R1 ctrl", d, 64'h1A000 + 64'(i + 2));
      win_rd(17 + 2 * i, d);
      chk("R1 dest", d, 64'hA0FF_0000);
    end

    // R4 version word
    win_rd(1, d);
    chk("R4 version", d, 64'h0020_0001);

    // R2 sweep of lower table
    for (int e = 0; e < 16; e++) if (e != 1) win_wr(e, pat(e));
    for (int e = 0; e < 16; e++) if (e != 1) begin
      win_rd(e, d);
      chk("R2 window", d, pat(e));
    end

    // R3 half-word accesses on entry 2
    wr(12'h800, 64'd2, 1'b1);
    wr(12'h814, 64'hCAFE_F00D, 1'b0);
    rd(12'h810, 1'b1, d);
    chk("R3 hi write", d, {32'hCAFE_F00D, pat(2)[31:0]});
    wr(12'h810, 64'h1234_5678, 1'b0);
    rd(12'h810, 1'b1, d);
    chk("R3 lo write", d, 64'hCAFE_F00D_1234_5678);
    rd(12'h810, 1'b0, d);
    chk("R3 lo read", d, 64'h1234_5678);
    rd(12'h814, 1'b0, d);
    chk("R3 hi read", d, 64'hCAFE_F00D);

    // R5 out-of-range select
    wr(12'h800, 64'h25, 1'b1);
    rd(12'h810, 1'b1, d);
    chk("R5 read ones", d, '1);
    rd(12'h810, 1'b0, d);
    chk("R5 read ones 32", d, 64'hFFFF_FFFF);
    wr(12'h810, 64'hDEAD, 1'b1);
    win_rd(5, d);
    chk("R5 write ignored", d, pat(5));

    // R6 R7 R8 per-line sweep
    for (int i = 0; i < N; i++) begin
      win_wr(16 + 2 * i, 64'hA000 | 64'(vecn(i)));
      base = n_msg;
      @(negedge clk); irq[i] = 1'b1;
      @(negedge clk);
      chk("R6 pend set", 64'(pend), 64'(1 << posn(i)));
      wait_n(5);
      chk("R7 one msg", 64'(n_msg), 64'(base + 1));
      chk("R7 data", 64'(log_data[base]), 64'(vecn(i)));
      chk("R7 addr", 64'(log_addr[base]), 64'hFFFA_0000);
      irq[i] = 1'b0;
      @(negedge clk);
      chk("R8 low clears", 64'(pend), 64'h0);
    end

    // R10 stall with all lines due
    mready = 1'b0;
    base = n_msg;
    irq = '1;
    wait_n(4);
    chk("R10 valid", 64'(mvalid), 64'h1);
    chk("R10 first", 64'(mdata), 64'(vecn(5)));
    wait_n(5);
    chk("R10 held", 64'(mdata), 64'(vecn(5)));
    chk("R10 no drain", 64'(n_msg), 64'(base));
    mready = 1'b1;
    wait_n(15);
    chk("R10 count", 64'(n_msg), 64'(base + 8));
    for (int k = 0; k < 8; k++)
      chk("R10 order", 64'(log_data[base + k]), 64'(vecn((k + 5) % 8)));
    irq = '0;
    wait_n(3);

    // R9 EOI with line held high
    irq[0] = 1'b1;
    wait_n(5);
    base = n_msg;
    wr(12'h840, 64'(vecn(0)), 1'b0);
    chk("R9 eoi clears", 64'(pend[posn(0)]), 64'h0);
    @(negedge clk);
    chk("R9 re-set", 64'(pend[posn(0)]), 64'h1);
    wait_n(4);
    chk("R9 resend", 64'(n_msg), 64'(base + 1));
    wr(12'h840, 64'h3F, 1'b0);
    wait_n(4);
    chk("R9 no match pend", 64'(pend[posn(0)]), 64'h1);
    chk("R9 no match msg", 64'(n_msg), 64'(base + 1));
    irq[0] = 1'b0;
    wait_n(3);

    // R12 EOI and line rise in the same cycle
    base = n_msg;
    @(negedge clk);
    irq[1] = 1'b1;
    req = 1'b1; we = 1'b1; wide = 1'b0; addr = 10'(12'h840 >> 2); wdata = 64'(vecn(1));
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R12 eoi wins", 64'(pend[posn(1)]), 64'h0);
    @(negedge clk);
    chk("R12 set next", 64'(pend[posn(1)]), 64'h1);
    wait_n(5);
    chk("R12 one msg", 64'(n_msg), 64'(base + 1));
    irq[1] = 1'b0;
    wait_n(3);

    // R8 mask clears pending
    irq[2] = 1'b1;
    wait_n(5);
    chk("R8 pre-mask", 64'(pend[posn(2)]), 64'h1);
    base = n_msg;
    win_wr(20, 64'h1A000 | 64'(vecn(2)));
    @(negedge clk);
    chk("R8 mask clears", 64'(pend[posn(2)]), 64'h0);
    wait_n(3);
    chk("R8 no msg", 64'(n_msg), 64'(base));
    irq[2] = 1'b0;
    win_wr(20, 64'hA000 | 64'(vecn(2)));

    // R11 zero destination
    win_wr(21, 64'h0);
    base = n_msg;
    irq[2] = 1'b1;
    wait_n(5);
    chk("R11 no pend", 64'(pend), 64'h0);
    chk("R11 no msg", 64'(n_msg), 64'(base));
    irq[2] = 1'b0;

    // R7 custom swizzled destination
    win_wr(23, 64'hAB12_0000);
    base = n_msg;
    irq[3] = 1'b1;
    wait_n(5);
    chk("R7 custom addr", 64'(log_addr[base]), 64'(unpack_hpa(32'hAB12_0000)));
    chk("R7 custom data", 64'(log_data[base]), 64'(vecn(3)));
    irq[3] = 1'b0;
    wait_n(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule